// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital control core for an eight-input successive-approximation converter. It holds a configuration word and derives a converter clock enable from the system clock. It picks the input channel and times each conversion by counting converter clocks. At the end of each conversion it captures the sample that the analog side presents. It runs one conversion at a time. A conversion can be started once by software, once by a chosen edge on one of six external trigger lines, or continuously in a burst scan of all selected channels.

Software loads the configuration through a single write strobe. It uses bits [7:0] as the channel mask, [15:8] as the clock divisor, [18:16] as the burst clock code, [19] as burst enable, [20] as power enable, [23:21] as the start code and [24] as the trigger polarity. Every finished conversion gives a one-cycle `done` pulse, together with the channel number and the result right-justified to the precision in force.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While power (bit 20) is 1, `adc_clk_en` pulses high for one cycle every divisor+1 system clock cycles, using the divisor in bits [15:8]. While power is 0 it stays low.
- R2: A channel mask of zero behaves as if only channel 0 were selected.
- R3: With burst (bit 19) at 0, a write of start code 001 produces exactly one conversion. It runs on the lowest selected channel and lasts 11 converter-clock pulses. Its result is the full 10-bit sample.
- R4: In burst mode, clock code k in bits [18:16] gives conversions of 11-k converter-clock pulses. The result is the upper 10-k bits of the sample, right-justified (sample >> k).
- R5: In burst mode, conversions repeat with no pause. The first one uses the lowest selected channel, each next one uses the next higher selected channel, and the scan wraps from the highest back to the lowest.
- R6: If burst is cleared while a conversion is running, that conversion still completes with its `done` pulse, and no further conversion begins.
- R7: While burst is 1 and the start code is not 000, no conversion begins.
- R8: With burst at 0, start code c in 010..111 starts a conversion on an edge of `trig_in[c-2]`. Polarity bit 24 at 0 selects the rising edge and at 1 the falling edge. Trigger inputs pass through a two-stage synchronizer first.
- R9: While power is 0 the controller stays idle: no conversion runs and none begins.
- R10: A trigger edge that arrives while a conversion is running is ignored.
- R11: `done` rises in the cycle after the last converter-clock pulse of a conversion. With divisor 0 in burst mode, successive `done` pulses are N+1 cycles apart, where N is the number of clocks per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 25 | Configuration word (field layout in the requirements) |
| trig_in | input | 6 | Asynchronous external start triggers |
| sample_in | input | 10 | Sample from the analog converter, valid at conversion end |
| adc_clk_en | output | 1 | Converter clock enable, one pulse per converter clock |
| conv_busy | output | 1 | A conversion is in progress |
| conv_chan | output | 3 | Channel being converted |
| done | output | 1 | One-cycle conversion-complete pulse |
| done_chan | output | 3 | Channel of the completed conversion |
| done_result | output | 10 | Right-justified result of the completed conversion |

## Verification
Two events can land on the same clock edge: the configuration write that clears burst and the final converter-clock tick of the running conversion. The bench counts `done` pulses during a burst scan. When it sees the second-to-last expected pulse, it waits exactly one conversion length and then issues the write so that the register update coincides with the completion. It judges the result by requiring the last `done` with the correct channel and result, followed by silence. A second collision, a trigger edge during a busy conversion, is provoked by toggling the selected trigger a few cycles after `conv_busy` rises and then requiring exactly one completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CH_N   = 8;
    localparam int CH_W   = $clog2(CH_N);
    localparam int DIV_W  = 8;
    localparam int RES_W  = 10;
    localparam int CODE_W = 3;
    localparam int TRIG_N = 6;
    localparam int CNT_W  = $clog2(RES_W + 2);

    typedef struct packed {
        logic              pol;
        logic [2:0]        start;
        logic              pwr;
        logic              burst;
        logic [CODE_W-1:0] clks;
        logic [DIV_W-1:0]  div;
        logic [CH_N-1:0]   mask;
    } cfg_t;

    localparam int CFG_BITS = $bits(cfg_t);

    localparam logic [2:0] ST_NONE  = 3'd0;
    localparam logic [2:0] ST_NOW   = 3'd1;
    localparam logic [2:0] ST_EDGE0 = 3'd2;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q >= div_i);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0)); // R1
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        // [0] first stage, [1] synchronized level, [2] previous level
        logic [2:0] sh_d, sh_q;

        always_comb sh_d = {sh_q[1:0], trig_i[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise_o[g] =  sh_q[1] & ~sh_q[2];
        assign fall_o[g] = ~sh_q[1] &  sh_q[2];
    end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
    parameter int CH_N = 8,
    parameter int CH_W = $clog2(CH_N)
) (
    input  logic [CH_N-1:0] mask_i,
    input  logic [CH_W-1:0] cur_i,
    output logic [CH_W-1:0] first_o,
    output logic [CH_W-1:0] next_o
);
    always_comb begin
        first_o = '0;
        for (int i = CH_N - 1; i >= 0; i--)
            if (mask_i[i]) first_o = CH_W'(i);
        next_o = first_o;
        for (int i = CH_N - 1; i >= 0; i--)
            if (mask_i[i] && i > int'(cur_i)) next_o = CH_W'(i);
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_BITS-1:0] cfg_data,
    input  logic [TRIG_N-1:0]   trig_in,
    input  logic [RES_W-1:0]    sample_in,
    output logic                adc_clk_en,
    output logic                conv_busy,
    output logic [CH_W-1:0]     conv_chan,
    output logic                done,
    output logic [CH_W-1:0]     done_chan,
    output logic [RES_W-1:0]    done_result
);
    typedef struct packed {
        cfg_t             cfg;
        logic             busy;
        logic             burst_run;
        logic             sw_pend;
        logic [CH_W-1:0]  chan;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] nclk;
        logic [CNT_W-1:0] nbits;
        logic             done;
        logic [CH_W-1:0]  done_chan;
        logic [RES_W-1:0] res;
    } st_t;

    st_t s_d, s_q;

    logic              tick;
    logic [TRIG_N-1:0] rise, fall;
    logic [CH_N-1:0]   eff_mask;
    logic [CH_W-1:0]   first_ch, next_ch;
    logic [2:0]        tidx;
    logic              edge_hit;
    cfg_t              wcfg;

    assign wcfg     = cfg_data;
    assign eff_mask = (s_q.cfg.mask == '0) ? CH_N'(1) : s_q.cfg.mask;

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(s_q.cfg.pwr),
        .div_i(s_q.cfg.div), .tick_o(tick)
    );

    adc_trig_edge #(.N(TRIG_N)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_in),
        .rise_o(rise), .fall_o(fall)
    );

    adc_chan_pick #(.CH_N(CH_N), .CH_W(CH_W)) u_pick (
        .mask_i(eff_mask), .cur_i(s_q.chan),
        .first_o(first_ch), .next_o(next_ch)
    );

    always_comb begin
        tidx     = s_q.cfg.start - ST_EDGE0;
        edge_hit = (s_q.cfg.start >= ST_EDGE0) &&
                   (s_q.cfg.pol ? fall[tidx] : rise[tidx]);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.cfg.pwr) begin
            s_d.busy      = 1'b0;
            s_d.burst_run = 1'b0;
            s_d.sw_pend   = 1'b0;
            s_d.cnt       = '0;
        end else if (s_q.busy) begin
            if (tick) begin
                if (s_q.cnt == s_q.nclk - 1'b1) begin
                    s_d.busy      = 1'b0;
                    s_d.done      = 1'b1;
                    s_d.done_chan = s_q.chan;
                    s_d.res       = sample_in >> (CNT_W'(RES_W) - s_q.nbits);
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else if (s_q.cfg.burst) begin
            if (s_q.cfg.start == ST_NONE) begin
                s_d.busy      = 1'b1;
                s_d.cnt       = '0;
                s_d.chan      = s_q.burst_run ? next_ch : first_ch;
                s_d.nclk      = CNT_W'(RES_W + 1) - CNT_W'(s_q.cfg.clks);
                s_d.nbits     = CNT_W'(RES_W) - CNT_W'(s_q.cfg.clks);
                s_d.burst_run = 1'b1;
            end
        end else begin
            s_d.burst_run = 1'b0;
            if (s_q.sw_pend || edge_hit) begin
                s_d.busy    = 1'b1;
                s_d.cnt     = '0;
                s_d.chan    = first_ch;
                s_d.nclk    = CNT_W'(RES_W + 1);
                s_d.nbits   = CNT_W'(RES_W);
                s_d.sw_pend = 1'b0;
            end
        end
        if (cfg_wr) begin
            s_d.cfg = wcfg;
            if (wcfg.start == ST_NOW && !wcfg.burst && wcfg.pwr)
                s_d.sw_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign adc_clk_en  = tick;
    assign conv_busy   = s_q.busy;
    assign conv_chan   = s_q.chan;
    assign done        = s_q.done;
    assign done_chan   = s_q.done_chan;
    assign done_result = s_q.res;

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> $past(s_q.busy)); // R11
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy)) |-> $stable(s_q.chan)); // R5
    AST_BURST_START_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> !($past(s_q.cfg.burst) && $past(s_q.cfg.start) != ST_NONE)); // R7
    AST_PWR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cfg.pwr |=> !s_q.busy); // R9
    AST_RES_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> ((s_q.res >> s_q.nbits) == '0)); // R4
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [24:0] cfg_data = '0;
    logic [5:0]  trig_in = '0;
    logic [9:0]  sample_in;
    logic        adc_clk_en, conv_busy, done;
    logic [2:0]  conv_chan, done_chan;
    logic [9:0]  done_result;

    always #10 clk = ~clk;

    function automatic logic [9:0] samp(input logic [2:0] ch);
        return 10'h155 + 10'(ch) * 10'd97;
    endfunction

    assign sample_in = samp(conv_chan);

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .trig_in(trig_in), .sample_in(sample_in), .adc_clk_en(adc_clk_en),
        .conv_busy(conv_busy), .conv_chan(conv_chan), .done(done),
        .done_chan(done_chan), .done_result(done_result)
    );

    typedef struct { int ch; int res; int nclk; int gap; } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0, done_cnt = 0, cyc = 0, last_done = 0, tick_cnt = 0;
    bit fin = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] mask, input logic [7:0] div,
                      input logic [2:0] clks, input logic burst, input logic pwr,
                      input logic [2:0] start, input logic pol);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_data = {pol, start, pwr, burst, clks, div, mask};
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic push(input int ch, input int res, input int nclk, input int gap);
        exp_t e;
        e.ch = ch; e.res = res; e.nclk = nclk; e.gap = gap;
        exp_q.push_back(e);
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, req, "missing conversions", exp_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_dones(input int k);
        int seen = 0;
        while (seen < k) begin
            @(negedge clk);
            if (done) seen++;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (conv_busy && adc_clk_en) tick_cnt++;
            if (done) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected done on channel", done_chan, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(done_chan) == e.ch, "R5", "done channel", done_chan, e.ch);
                    chk(int'(done_result) == e.res, "R4", "result", done_result, e.res);
                    chk(tick_cnt == e.nclk, "R3", "converter clocks", tick_cnt, e.nclk);
                    if (e.gap != 0)
                        chk(cyc - last_done == e.gap, "R11", "done spacing",
                            cyc - last_done, e.gap);
                end
                tick_cnt  = 0;
                last_done = cyc;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            chk(1'b0, "R11", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base, en_cnt, p0, p1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(done == 1'b0, "R9", "reset done", done, 0);
        chk(conv_busy == 1'b0, "R9", "reset busy", conv_busy, 0);
        chk(adc_clk_en == 1'b0, "R1", "reset clock enable", adc_clk_en, 0);

        // R1: divisor 4 gives a pulse every 5 cycles
        wr(8'h01, 8'd4, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0);
        en_cnt = 0; p0 = -1; p1 = -1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (adc_clk_en) begin
                en_cnt++;
                if (p0 < 0) p0 = i; else if (p1 < 0) p1 = i;
            end
        end
        chk(en_cnt == 10, "R1", "pulses in 50 cycles", en_cnt, 10);
        chk(p1 - p0 == 5, "R1", "pulse period", p1 - p0, 5);

        // R9: power off, software start ignored
        wr(8'h01, 8'd0, 3'd0, 1'b0, 1'b0, 3'd1, 1'b0);
        base = done_cnt; en_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (adc_clk_en || conv_busy) en_cnt++;
        end
        chk(en_cnt == 0, "R9", "activity while powered down", en_cnt, 0);
        chk(done_cnt == base, "R9", "done while powered down", done_cnt - base, 0);

        // R3: software start, lowest selected channel, divisor 2
        base = done_cnt;
        push(2, samp(3'd2), 11, 0);
        wr(8'h24, 8'd2, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0);
        drain("R3");
        repeat (60) @(negedge clk);
        chk(done_cnt - base == 1, "R3", "conversions per start", done_cnt - base, 1);

        // R2: empty mask converts channel 0
        push(0, samp(3'd0), 11, 0);
        wr(8'h00, 8'd0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0);
        drain("R2");

        // R7: burst with nonzero start code never converts
        base = done_cnt;
        wr(8'hFF, 8'd0, 3'd0, 1'b1, 1'b1, 3'd1, 1'b0);
        repeat (60) @(negedge clk);
        chk(done_cnt == base, "R7", "done with burst and start code", done_cnt - base, 0);

        // R5, R6, R11: scan 2,5,7 wrapping; clear burst on the 5th completion edge
        wr(8'h00, 8'd0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0);
        base = done_cnt;
        push(2, samp(3'd2), 11, 0);
        push(5, samp(3'd5), 11, 12);
        push(7, samp(3'd7), 11, 12);
        push(2, samp(3'd2), 11, 12);
        push(5, samp(3'd5), 11, 12);
        wr(8'hA4, 8'd0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0);
        wait_dones(4);
        repeat (10) @(negedge clk);
        wr(8'hA4, 8'd0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0);
        drain("R6");
        repeat (60) @(negedge clk);
        chk(done_cnt - base == 5, "R6", "conversions after burst clear", done_cnt - base, 5);

        // R4: 6-clock, 5-bit burst on channels 0 and 3
        base = done_cnt;
        push(0, samp(3'd0) >> 5, 6, 0);
        push(3, samp(3'd3) >> 5, 6, 7);
        push(0, samp(3'd0) >> 5, 6, 7);
        wr(8'h09, 8'd0, 3'd5, 1'b1, 1'b1, 3'd0, 1'b0);
        wait_dones(2);
        repeat (5) @(negedge clk);
        wr(8'h09, 8'd0, 3'd5, 1'b0, 1'b1, 3'd0, 1'b0);
        drain("R4");
        repeat (30) @(negedge clk);
        chk(done_cnt - base == 3, "R4", "reduced-precision conversions", done_cnt - base, 3);

        // R8: rising edge on trigger 0 (code 010)
        wr(8'h10, 8'd0, 3'd0, 1'b0, 1'b1, 3'd2, 1'b0);
        push(4, samp(3'd4), 11, 0);
        @(negedge clk); trig_in[0] = 1'b1;
        drain("R8");

        // R8: falling polarity on trigger 2 (code 100); rise must not start
        wr(8'h10, 8'd0, 3'd0, 1'b0, 1'b1, 3'd4, 1'b1);
        base = done_cnt;
        @(negedge clk); trig_in[2] = 1'b1;
        repeat (40) @(negedge clk);
        chk(done_cnt == base, "R8", "done on wrong polarity", done_cnt - base, 0);
        push(4, samp(3'd4), 11, 0);
        trig_in[2] = 1'b0;
        drain("R8");

        // R10: second edge on trigger 1 while busy is ignored
        wr(8'h40, 8'd0, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0);
        base = done_cnt;
        push(6, samp(3'd6), 11, 0);
        @(negedge clk); trig_in[1] = 1'b1;
        while (!conv_busy) @(negedge clk);
        trig_in[1] = 1'b0;
        repeat (3) @(negedge clk);
        trig_in[1] = 1'b1;
        drain("R10");
        repeat (40) @(negedge clk);
        chk(done_cnt - base == 1, "R10", "conversions for two edges", done_cnt - base, 1);

        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule